// File: doc/BRIEF.md
# Host Notification and Data-Ready Controller

This block drives two status lines toward a host that reads a touch-sensing front end over SPI. The first line, the change flag, tells the host that fresh status is waiting. It is raised by a status update, by newly applied threshold or low-power settings, or by an internal reset event. It also comes up on reset. Only a completed SPI frame lowers it.

The second line, data-ready, reflects the acquisition engine. It is low while a burst runs. After each burst it is high for a programmable window, and it stays high while idle. If a frame completes outside a burst, data-ready is pulled low and held low until the next burst has finished. A host that sees data-ready low when it expects it high therefore knows that a frame was lost or has slipped.

A short grace window follows each fall of data-ready at burst start. If a frame begins inside that window, data-ready returns high and stays high until the frame ends. A burst-inhibit output tells the acquisition engine to hold off bursts during that exchange. The same output also spaces bursts apart: it is asserted during the post-burst high window. All durations are counted in system-clock cycles.

Top module: `hostnotify_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `change_o`=1, `drdy_o`=1 and `burst_inhibit_o`=0.
- R2: A pulse on `status_chg_i`, `cfg_applied_i` or `reset_evt_i` makes `change_o` 1 on the next clock edge.
- R3: `change_o` falls only on the edge after a cycle with `frame_done_i`=1. Bursts, frame starts and the passage of time leave it unchanged.
- R4: If a set event and `frame_done_i` occur in the same cycle, `change_o` is 1 after that edge.
- R5: From the edge that samples `burst_active_i`=1 (data-ready idle or in its post-burst window), `drdy_o` is 0 for as long as the burst lasts, unless R8 applies.
- R6: On the edge that samples `burst_active_i`=0 after a burst, `drdy_o`=1 and `burst_inhibit_o`=1 for exactly HIGH_CYC cycles. After that `burst_inhibit_o`=0 and `drdy_o` stays 1.
- R7: A cycle with `frame_done_i`=1 while `drdy_o`=1 (idle, window or grace exchange) drives `drdy_o` to 0 on the next edge and clears `burst_inhibit_o`. `drdy_o` stays 0 until a burst has started and ended.
- R8: Let the burst's first edge be edge 0. If `frame_start_i`=1 is sampled on edges 1 to GRACE_CYC of a burst that began from a high data-ready, `drdy_o` and `burst_inhibit_o` go to 1. They stay 1, regardless of `burst_active_i`, until `frame_done_i`.
- R9: A `frame_start_i` sampled later than edge GRACE_CYC of a burst, or during a burst that began while data-ready was held low by R7, has no effect on `drdy_o` or `burst_inhibit_o`.
- R10: A `frame_done_i` during a burst outside a grace exchange leaves `drdy_o` low. The burst's end then produces the normal R6 window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_active_i | input | 1 | High while an acquisition burst runs |
| status_chg_i | input | 1 | Pulse: readable status data changed |
| cfg_applied_i | input | 1 | Pulse: new threshold or low-power setting applied |
| reset_evt_i | input | 1 | Pulse: sensing core went through a reset |
| frame_start_i | input | 1 | Pulse from the SPI framer: a frame began |
| frame_done_i | input | 1 | Pulse from the SPI framer: a full frame completed |
| change_o | output | 1 | Change notification to the host |
| drdy_o | output | 1 | Data-ready line to the host |
| burst_inhibit_o | output | 1 | Holds off the next acquisition burst |

## Verification
The bench builds the block with HIGH_CYC=6 and GRACE_CYC=3. These small values let it sweep every frame-start offset from the first burst edge to two edges past the grace limit, and every frame-done offset across the whole post-burst window. A reference flag in the bench tracks the expected change line on every clock. Every pulse, including the coincident set-and-clear case, is therefore checked against that flag.

// File: rtl/hostnotify_pkg.sv
package hostnotify_pkg;

    typedef enum logic [2:0] {
        DS_IDLE  = 3'd0,
        DS_BURST = 3'd1,
        DS_WIN   = 3'd2,
        DS_HOLD  = 3'd3,
        DS_GRACE = 3'd4
    } drdy_state_e;

    typedef struct packed {
        logic drdy;
        logic inhibit;
    } line_pair_t;

    function automatic int unsigned cnt_bits(input int unsigned a, input int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m < 1) ? 1 : $clog2(m + 1);
    endfunction

    function automatic line_pair_t decode_lines(input drdy_state_e s);
        line_pair_t l;
        l.drdy    = (s == DS_IDLE) || (s == DS_WIN) || (s == DS_GRACE);
        l.inhibit = (s == DS_WIN) || (s == DS_GRACE);
        return l;
    endfunction

endpackage

// File: rtl/hn_change_flag.sv
module hn_change_flag #(
    parameter int unsigned N_SET = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SET-1:0] set_i,
    input  logic             clear_i,
    output logic             flag_o
);
    logic any_set;

    assign any_set = |set_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b1;
        end else if (any_set) begin
            flag_o <= 1'b1;
        end else if (clear_i) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/hn_drdy_fsm.sv
module hn_drdy_fsm
    import hostnotify_pkg::*;
#(
    parameter int unsigned HIGH_CYC  = 25000,
    parameter int unsigned GRACE_CYC = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        burst_active_i,
    input  logic        frame_start_i,
    input  logic        frame_done_i,
    output drdy_state_e state_o
);
    localparam int unsigned CW = cnt_bits(HIGH_CYC, GRACE_CYC);
    localparam logic [CW-1:0] GRACE_L   = CW'(GRACE_CYC);
    localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_CYC - 1);

    drdy_state_e   state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            DS_IDLE: begin
                if (frame_done_i) begin
                    state_n = DS_HOLD;
                end else if (burst_active_i) begin
                    state_n = DS_BURST;
                    cnt_n   = '0;
                end
            end
            DS_BURST: begin
                if (frame_start_i && (cnt_q < GRACE_L)) begin
                    state_n = DS_GRACE;
                end else if (!burst_active_i) begin
                    state_n = DS_WIN;
                    cnt_n   = '0;
                end else if (cnt_q != GRACE_L) begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            DS_WIN: begin
                if (frame_done_i) begin
                    state_n = DS_HOLD;
                end else if (burst_active_i) begin
                    state_n = DS_BURST;
                    cnt_n   = '0;
                end else if (cnt_q == HIGH_LAST) begin
                    state_n = DS_IDLE;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            DS_HOLD: begin
                if (burst_active_i) begin
                    state_n = DS_BURST;
                    cnt_n   = GRACE_L;
                end
            end
            DS_GRACE: begin
                if (frame_done_i) begin
                    state_n = DS_HOLD;
                end
            end
            default: begin
                state_n = DS_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/hostnotify_ctrl.sv
module hostnotify_ctrl
    import hostnotify_pkg::*;
#(
    parameter int unsigned HIGH_CYC  = 25000,
    parameter int unsigned GRACE_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic burst_active_i,
    input  logic status_chg_i,
    input  logic cfg_applied_i,
    input  logic reset_evt_i,
    input  logic frame_start_i,
    input  logic frame_done_i,
    output logic change_o,
    output logic drdy_o,
    output logic burst_inhibit_o
);
    localparam int unsigned N_SET = 3;

    drdy_state_e state;
    line_pair_t  lines;

    hn_change_flag #(.N_SET(N_SET)) u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_i   ({reset_evt_i, cfg_applied_i, status_chg_i}),
        .clear_i (frame_done_i),
        .flag_o  (change_o)
    );

    hn_drdy_fsm #(.HIGH_CYC(HIGH_CYC), .GRACE_CYC(GRACE_CYC)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .burst_active_i (burst_active_i),
        .frame_start_i  (frame_start_i),
        .frame_done_i   (frame_done_i),
        .state_o        (state)
    );

    assign lines           = decode_lines(state);
    assign drdy_o          = lines.drdy;
    assign burst_inhibit_o = lines.inhibit;
endmodule

// File: rtl/hn_checker.sv
module hn_checker (
    input logic clk,
    input logic rst,
    input logic burst_active_i,
    input logic status_chg_i,
    input logic cfg_applied_i,
    input logic reset_evt_i,
    input logic frame_start_i,
    input logic frame_done_i,
    input logic change_o,
    input logic drdy_o,
    input logic burst_inhibit_o
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        (status_chg_i || cfg_applied_i || reset_evt_i) |=> change_o);

    assert_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (change_o && !frame_done_i) |=> change_o);

    assert_fall_cause_R3: assert property (@(posedge clk) disable iff (rst || !armed)
        $fell(change_o) |-> $past(frame_done_i));

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (frame_done_i && status_chg_i) |=> change_o);

    assert_burst_low_R5: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(burst_active_i) && !burst_inhibit_o) |-> !drdy_o);

    assert_inhibit_high_R8: assert property (@(posedge clk) disable iff (rst)
        burst_inhibit_o |-> drdy_o);

    assert_done_low_R7: assert property (@(posedge clk) disable iff (rst)
        (frame_done_i && drdy_o) |=> !drdy_o);
endmodule

bind hostnotify_ctrl hn_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .burst_active_i  (burst_active_i),
    .status_chg_i    (status_chg_i),
    .cfg_applied_i   (cfg_applied_i),
    .reset_evt_i     (reset_evt_i),
    .frame_start_i   (frame_start_i),
    .frame_done_i    (frame_done_i),
    .change_o        (change_o),
    .drdy_o          (drdy_o),
    .burst_inhibit_o (burst_inhibit_o)
);

// File: tb/hostnotify_ctrl_test.sv
module hostnotify_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int H = 6;
    localparam int G = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic burst = 1'b0, stc = 1'b0, cfg = 1'b0, rev = 1'b0, fs = 1'b0, fd = 1'b0;
    logic change, drdy, inh;
    logic exp_chg = 1'b1;
    int n_chk = 0, n_fail = 0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostnotify_ctrl #(.HIGH_CYC(H), .GRACE_CYC(G)) uut (
        .clk(clk), .rst(rst), .burst_active_i(burst), .status_chg_i(stc),
        .cfg_applied_i(cfg), .reset_evt_i(rev), .frame_start_i(fs),
        .frame_done_i(fd), .change_o(change), .drdy_o(drdy), .burst_inhibit_o(inh)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock; pulses are cleared afterwards; the change line is checked
    // against the expected flag on every edge (R2, R3, R4).
    task automatic tick();
        logic s, d;
        s = stc | cfg | rev;
        d = fd;
        @(posedge clk);
        #1;
        if (rst || s) exp_chg = 1'b1;
        else if (d)   exp_chg = 1'b0;
        if (rst)         chk("R1 change", change, exp_chg);
        else if (s && d) chk("R4 change", change, exp_chg);
        else if (s)      chk("R2 change", change, exp_chg);
        else             chk("R3 change", change, exp_chg);
        stc = 0; cfg = 0; rev = 0; fs = 0; fd = 0;
    endtask

    // Drop burst_active and check the R6 window, ending idle.
    task automatic end_burst();
        burst = 1'b0;
        for (int i = 1; i <= H; i++) begin
            tick();
            chk("R6 window drdy", drdy, 1'b1);
            chk("R6 window inhibit", inh, 1'b1);
        end
        tick();
        chk("R6 idle inhibit", inh, 1'b0);
        chk("R6 idle drdy", drdy, 1'b1);
    endtask

    initial begin
        tick(); tick();
        chk("R1 drdy in reset", drdy, 1'b1);
        chk("R1 inhibit in reset", inh, 1'b0);
        rst = 1'b0;
        tick();
        chk("R1 drdy", drdy, 1'b1);
        chk("R1 inhibit", inh, 1'b0);

        // R3: a frame start and a burst do not clear change
        fs = 1; tick();
        // R5: bursts of several lengths from idle
        for (int len = 1; len <= 4; len++) begin
            burst = 1'b1;
            for (int j = 0; j < len; j++) begin
                tick();
                chk("R5 burst drdy", drdy, 1'b0);
            end
            end_burst();
        end

        // R7: frame done from idle, then hold, then each set source (R2)
        fd = 1; tick();
        chk("R7 drdy low", drdy, 1'b0);
        chk("R7 inhibit low", inh, 1'b0);
        stc = 1; tick();
        fd = 1;  tick();
        cfg = 1; tick();
        fd = 1;  tick();
        rev = 1; tick();
        fd = 1;  tick();
        stc = 1; fd = 1; tick();   // R4
        cfg = 1; fd = 1; tick();   // R4
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R7 hold drdy", drdy, 1'b0);
        end
        // R9: burst from hold gets no grace
        burst = 1'b1; tick();
        chk("R7 burst from hold", drdy, 1'b0);
        fs = 1; tick();
        chk("R9 no grace after hold drdy", drdy, 1'b0);
        chk("R9 no grace after hold inhibit", inh, 1'b0);
        end_burst();

        // R8 / R9 sweep of the frame-start offset
        for (int k = 1; k <= G + 2; k++) begin
            burst = 1'b1; tick();
            chk("R5 burst start", drdy, 1'b0);
            for (int j = 1; j < k; j++) tick();
            fs = 1; tick();
            if (k <= G) begin
                chk("R8 grace drdy", drdy, 1'b1);
                chk("R8 grace inhibit", inh, 1'b1);
                tick(); tick();
                chk("R8 grace held drdy", drdy, 1'b1);
                burst = 1'b0; tick();
                chk("R8 grace held inhibit", inh, 1'b1);
                chk("R8 grace held after burst", drdy, 1'b1);
                fd = 1; tick();
                chk("R7 grace end drdy", drdy, 1'b0);
                chk("R7 grace end inhibit", inh, 1'b0);
                tick();
                chk("R7 hold after grace", drdy, 1'b0);
                burst = 1'b1; tick();
                chk("R7 burst in hold", drdy, 1'b0);
                end_burst();
            end else begin
                chk("R9 late start drdy", drdy, 1'b0);
                chk("R9 late start inhibit", inh, 1'b0);
                end_burst();
            end
        end

        // R7 sweep of the frame-done offset inside the window
        for (int j = 1; j <= H; j++) begin
            stc = 1;
            burst = 1'b1; tick();
            burst = 1'b0; tick();
            for (int i = 1; i < j; i++) tick();
            chk("R6 window before done", inh, 1'b1);
            fd = 1; tick();
            chk("R7 done in window drdy", drdy, 1'b0);
            chk("R7 done in window inhibit", inh, 1'b0);
            for (int i = 0; i < H + 2; i++) tick();
            chk("R7 still held", drdy, 1'b0);
            burst = 1'b1; tick();
            end_burst();
        end

        // R10: frame done during an ordinary burst
        burst = 1'b1; tick(); tick(); tick(); tick();
        fd = 1; tick();
        chk("R10 done in burst drdy", drdy, 1'b0);
        tick();
        chk("R10 burst continues", drdy, 1'b0);
        end_burst();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule